// File: doc/BRIEF.md
# Bulk-IN Endpoint Buffer Controller

This block holds outgoing bytes for one bulk-IN endpoint of a USB device. A CPU or DMA engine writes bytes into it one at a time. The block collects them into packets of at most 64 bytes in two ping-pong packet buffers. A packet is offered to the host once its 64th byte lands, or earlier when firmware pulses a packet-commit strobe. A commit pulse on an empty fill buffer yields a zero-length packet.

On the serial side, the token decoder hands the block a one-cycle IN-token strobe. The block answers with a NACK pulse if nothing is committed. Otherwise it streams the oldest committed packet one byte per cycle and then waits. A host ACK frees that buffer. A timeout strobe keeps the packet, so it is sent again on the next IN token.

A single "space free" condition drives three outputs. The first is a sticky empty-status flag that firmware clears. The second is an interrupt gated by an enable input. The third is a DMA transfer request that is gated by a DMA-enable input.

Top module: `bulk_in_ep`

## Requirements
- R1: An IN token that arrives while no packet is committed produces a one-cycle `nack` pulse in the following cycle, and no byte is sent.
- R2: An IN token that arrives while a non-empty packet is committed starts a stream in the following cycle. The stream carries one byte per cycle on `tx_data` with `tx_valid` high, in write order, with `tx_last` high only on the final byte. After the stream, the block waits for the host's answer.
- R3: A packet is committed without any strobe when its 64th byte is written.
- R4: A `pkt_commit` pulse commits the bytes written so far as a short packet. When the fill buffer holds no bytes, the commit produces a zero-length packet. That packet is answered on the next IN token by a one-cycle `tx_zlp` pulse with no data.
- R5: A `host_ack` after a packet frees its buffer. A `host_timeout` instead keeps the packet, and the next IN token resends the same bytes.
- R6: Two packet buffers exist, so up to 128 bytes (two full packets) are accepted before any is acknowledged. Space counts as free while at least one buffer is not holding a committed packet.
- R7: `empty_flag` is 1 after reset. It is set again each time a buffer is freed by ACK. An `empty_clr` pulse clears it, but a release in the same cycle wins over the clear.
- R8: `irq` is high exactly when `empty_flag` is 1 and `empty_ie` is 1.
- R9: `dma_req` is high while `dma_en` is 1 and space is free. It drops when `dma_en` goes to 0 or when both buffers hold committed packets.
- R10: A byte written while no space is free is dropped and sets `ovf_err`. `ovf_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to write |
| pkt_commit | input | 1 | Commit the partially filled packet |
| empty_clr | input | 1 | Clear the empty-status flag |
| empty_ie | input | 1 | Interrupt enable for the empty flag |
| dma_en | input | 1 | DMA mode enable |
| in_token | input | 1 | IN token received strobe |
| host_ack | input | 1 | Host ACK handshake strobe |
| host_timeout | input | 1 | No handshake before timeout strobe |
| tx_valid | output | 1 | Data byte valid toward serial engine |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Send a zero-length packet |
| nack | output | 1 | Answer the token with NACK |
| empty_flag | output | 1 | Sticky space-free status |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA transfer request |
| ovf_err | output | 1 | Sticky write-overflow error |

## Verification
The main path is tried with five patterns:
- a 64-byte packet that commits itself;
- a 5-byte packet closed by the strobe;
- a strobe on an empty buffer;
- two back-to-back full packets;
- a token with nothing pending.

Between them, these separate auto-commit from strobe commit, a data reply from a zero-length reply and from a NACK, and correct ping-pong ordering from a swapped or repeated buffer. A timeout followed by a second token shows whether the packet is kept rather than freed. An extra byte written after both buffers fill shows whether the byte is really dropped and whether the overflow, flag, interrupt and DMA outputs follow space correctly.

// File: rtl/bin_pkg.sv
package bin_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;

  // Fill count after an optional accepted byte
  function automatic int fill_next(int cnt, logic take);
    return cnt + (take ? 1 : 0);
  endfunction

  // True when index idx is the final byte of a packet of length len
  function automatic logic pkt_last(int idx, int len);
    return (idx + 1) == len;
  endfunction
endpackage

// File: rtl/bin_pktbuf.sv
module bin_pktbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wsel == 1'(b))) mem[waddr] <= wdata;
    end
    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = bank_rd[rsel];
endmodule

// File: rtl/bin_fill.sv
module bin_fill
  import bin_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1),
  localparam int AW    = $clog2(MAXPKT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  input  logic                 commit,
  input  logic                 space,
  output logic                 mem_we,
  output logic                 mem_sel,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 cmt,
  output logic                 wbuf,
  output logic [1:0][CW-1:0]   len_q,
  output logic                 ovf
);
  logic [CW-1:0] fill_cnt;
  logic [CW-1:0] eff_len;
  logic          wr_take;

  assign wr_take   = wr_en && space;
  assign eff_len   = CW'(fill_next(int'(fill_cnt), wr_take));
  assign cmt       = space && (commit || (eff_len == CW'(MAXPKT)));
  assign mem_we    = wr_take;
  assign mem_sel   = wbuf;
  assign mem_addr  = fill_cnt[AW-1:0];
  assign mem_wdata = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      wbuf     <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (wr_en && !space) ovf <= 1'b1;
      if (cmt) begin
        wbuf     <= ~wbuf;
        fill_cnt <= '0;
      end else if (wr_take) begin
        fill_cnt <= eff_len;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        len_q[b] <= '0;
      else if (cmt && (wbuf == 1'(b)))   len_q[b] <= eff_len;
    end
  end
endmodule

// File: rtl/bin_txctl.sv
module bin_txctl
  import bin_pkg::*;
#(
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1),
  localparam int AW    = $clog2(MAXPKT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_token,
  input  logic               host_ack,
  input  logic               host_timeout,
  input  logic [1:0]         vld,
  input  logic [1:0][CW-1:0] len_q,
  output logic               rbuf,
  output logic [AW-1:0]      raddr,
  output logic               tx_valid,
  output logic               tx_last,
  output logic               tx_zlp,
  output logic               nack,
  output logic               rel,
  output logic               idle,
  output logic               rd_vld
);
  tx_state_e     state;
  logic [CW-1:0] rcnt;
  logic [CW-1:0] cur_len;

  assign cur_len  = len_q[rbuf];
  assign rd_vld   = vld[rbuf];
  assign idle     = (state == TX_IDLE);
  assign tx_valid = (state == TX_SEND);
  assign tx_last  = tx_valid && pkt_last(int'(rcnt), int'(cur_len));
  assign raddr    = rcnt[AW-1:0];
  assign rel      = (state == TX_WAIT) && host_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      rcnt   <= '0;
      rbuf   <= 1'b0;
      tx_zlp <= 1'b0;
      nack   <= 1'b0;
    end else begin
      tx_zlp <= 1'b0;
      nack   <= 1'b0;
      unique case (state)
        TX_IDLE: if (in_token) begin
          if (!rd_vld) begin
            nack <= 1'b1;
          end else if (cur_len == '0) begin
            tx_zlp <= 1'b1;
            state  <= TX_WAIT;
          end else begin
            rcnt  <= '0;
            state <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (tx_last) state <= TX_WAIT;
          else         rcnt  <= rcnt + CW'(1);
        end
        TX_WAIT: begin
          if (host_ack) begin
            rbuf  <= ~rbuf;
            state <= TX_IDLE;
          end else if (host_timeout) begin
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bulk_in_ep.sv
module bulk_in_ep #(
  parameter int DW     = 8,
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1),
  localparam int AW    = $clog2(MAXPKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_commit,
  input  logic          empty_clr,
  input  logic          empty_ie,
  input  logic          dma_en,
  input  logic          in_token,
  input  logic          host_ack,
  input  logic          host_timeout,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          nack,
  output logic          empty_flag,
  output logic          irq,
  output logic          dma_req,
  output logic          ovf_err
);
  logic [1:0]         vld;
  logic [1:0][CW-1:0] len_q;
  logic               space_w, cmt_w, rel_w, idle_w, rd_vld_w;
  logic               wbuf, rbuf;
  logic               mem_we, mem_sel;
  logic [AW-1:0]      mem_addr, raddr;
  logic [DW-1:0]      mem_wdata;

  assign space_w = !vld[wbuf];

  bin_fill #(.DW(DW), .MAXPKT(MAXPKT)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .commit(pkt_commit), .space(space_w), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmt(cmt_w), .wbuf(wbuf), .len_q(len_q), .ovf(ovf_err)
  );

  bin_pktbuf #(.DW(DW), .DEPTH(MAXPKT)) u_buf (
    .clk(clk), .we(mem_we), .wsel(mem_sel), .waddr(mem_addr),
    .wdata(mem_wdata), .rsel(rbuf), .raddr(raddr), .rdata(tx_data)
  );

  bin_txctl #(.MAXPKT(MAXPKT)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_token(in_token), .host_ack(host_ack),
    .host_timeout(host_timeout), .vld(vld), .len_q(len_q), .rbuf(rbuf),
    .raddr(raddr), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_zlp(tx_zlp), .nack(nack), .rel(rel_w), .idle(idle_w),
    .rd_vld(rd_vld_w)
  );

  for (genvar b = 0; b < 2; b++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld[b] <= 1'b0;
      else        vld[b] <= (vld[b] && !(rel_w && (rbuf == 1'(b))))
                            || (cmt_w && (wbuf == 1'(b)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         empty_flag <= 1'b1;
    else if (rel_w)     empty_flag <= 1'b1;
    else if (empty_clr) empty_flag <= 1'b0;
  end

  assign irq     = empty_flag && empty_ie;
  assign dma_req = dma_en && space_w;
endmodule

// File: rtl/bin_chk.sv
module bin_chk (
  input logic clk,
  input logic rst_n,
  input logic in_token,
  input logic host_ack,
  input logic empty_clr,
  input logic empty_ie,
  input logic dma_en,
  input logic wr_en,
  input logic tx_valid,
  input logic tx_zlp,
  input logic nack,
  input logic empty_flag,
  input logic irq,
  input logic dma_req,
  input logic ovf_err,
  input logic idle_w,
  input logic rd_vld_w,
  input logic rel_w,
  input logic space_w
);
  // R1
  nack_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && idle_w && !rd_vld_w) |=> (nack && !tx_valid));

  // R2
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, tx_zlp, nack}));

  // R7
  flag_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_w |=> empty_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_clr && !rel_w) |=> !empty_flag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_ie |-> !irq);

  // R9
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en || !space_w) |-> !dma_req);

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !space_w) |=> ovf_err);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R5
  ack_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && idle_w) |=> $stable(empty_flag) || !empty_flag || $past(empty_flag));
endmodule

bind bulk_in_ep bin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_token(in_token), .host_ack(host_ack),
  .empty_clr(empty_clr), .empty_ie(empty_ie), .dma_en(dma_en),
  .wr_en(wr_en), .tx_valid(tx_valid), .tx_zlp(tx_zlp), .nack(nack),
  .empty_flag(empty_flag), .irq(irq), .dma_req(dma_req),
  .ovf_err(ovf_err), .idle_w(idle_w), .rd_vld_w(rd_vld_w),
  .rel_w(rel_w), .space_w(space_w)
);

// File: tb/tb_bulk_in_ep.sv
module tb_bulk_in_ep;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, pkt_commit = 0, empty_clr = 0, empty_ie = 0, dma_en = 0;
  logic in_token = 0, host_ack = 0, host_timeout = 0;
  logic [7:0] wr_data = '0;
  logic tx_valid, tx_last, tx_zlp, nack, empty_flag, irq, dma_req, ovf_err;
  logic [7:0] tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bulk_in_ep dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pkt_commit(pkt_commit), .empty_clr(empty_clr), .empty_ie(empty_ie),
    .dma_en(dma_en), .in_token(in_token), .host_ack(host_ack),
    .host_timeout(host_timeout), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_zlp(tx_zlp), .nack(nack),
    .empty_flag(empty_flag), .irq(irq), .dma_req(dma_req), .ovf_err(ovf_err)
  );

  typedef struct packed { logic [1:0] kind; logic [7:0] dat; logic last; } item_t;
  localparam logic [1:0] K_DATA = 2'd0, K_ZLP = 2'd1, K_NACK = 2'd2;

  item_t exp_q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model of the two packet slots
  logic [7:0] m_dat [2][64];
  int m_len [2];
  int m_wr = 0, m_rd = 0, m_cnt = 0, m_fill = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare serial-side outputs against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (tx_valid || tx_zlp || nack)) begin
      item_t got, want;
      got.kind = tx_valid ? K_DATA : (tx_zlp ? K_ZLP : K_NACK);
      got.dat  = tx_valid ? tx_data : 8'h00;
      got.last = tx_valid ? tx_last : 1'b0;
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2 unexpected reply actual=%0h expected=none", got);
      end else begin
        want = exp_q.pop_front();
        check("R1/R2/R4 reply", int'(got), int'(want));
      end
    end
  end

  task automatic m_commit();
    m_len[m_wr] = m_fill; m_wr ^= 1; m_fill = 0; m_cnt++;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    if (m_cnt < 2) begin
      m_dat[m_wr][m_fill] = b; m_fill++;
      if (m_fill == 64) m_commit();
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_commit();
    @(negedge clk); pkt_commit = 1;
    if (m_cnt < 2) m_commit();
    @(negedge clk); pkt_commit = 0;
  endtask

  task automatic token();
    item_t it;
    if (m_cnt == 0) begin
      it.kind = K_NACK; it.dat = 0; it.last = 0; exp_q.push_back(it);
    end else if (m_len[m_rd] == 0) begin
      it.kind = K_ZLP; it.dat = 0; it.last = 0; exp_q.push_back(it);
    end else begin
      for (int i = 0; i < m_len[m_rd]; i++) begin
        it.kind = K_DATA; it.dat = m_dat[m_rd][i];
        it.last = (i == m_len[m_rd] - 1); exp_q.push_back(it);
      end
    end
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); host_ack = 1;
    m_rd ^= 1; m_cnt--;
    @(negedge clk); host_ack = 0;
  endtask

  task automatic tmo();
    @(negedge clk); host_timeout = 1;
    @(negedge clk); host_timeout = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); empty_clr = 1;
    @(negedge clk); empty_clr = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R7 flag after reset", empty_flag, 1);
    check("R8 irq after reset", irq, 0);
    check("R9 dma_req after reset", dma_req, 0);
    check("R10 ovf after reset", ovf_err, 0);
    check("R2 tx_valid after reset", tx_valid, 0);
    // interrupt gating and flag clear
    empty_ie = 1; #1;
    check("R8 irq enabled", irq, 1);
    clr_flag();
    check("R7 flag cleared", empty_flag, 0);
    check("R8 irq follows flag", irq, 0);
    empty_ie = 0;
    // nothing committed
    token();                                              // R1
    // full packet, auto commit
    for (int i = 0; i < 64; i++) wr_byte(8'(i * 3 + 1));  // R3
    token();                                              // R2 R3
    ack();
    @(negedge clk);
    check("R7 flag set on release", empty_flag, 1);
    // short packet, timeout, resend
    for (int i = 0; i < 5; i++) wr_byte(8'(8'hA0 + i));
    do_commit();                                          // R4
    token();
    tmo();
    token();                                              // R5 resend
    ack();
    // zero-length packet
    do_commit();
    token();                                              // R4 zlp
    ack();
    // both buffers, DMA and overflow
    clr_flag();
    dma_en = 1; #1;
    check("R9 dma_req with space", dma_req, 1);
    for (int i = 0; i < 128; i++) wr_byte(8'(8'h40 ^ i));
    #1;
    check("R6 dma_req after 128 bytes", dma_req, 0);
    check("R7 flag unchanged while full", empty_flag, 0);
    wr_byte(8'hEE);
    check("R10 ovf set", ovf_err, 1);
    token();                                              // R6 first packet
    ack();
    @(negedge clk);
    check("R7 flag after ack", empty_flag, 1);
    check("R9 dma_req back", dma_req, 1);
    token();                                              // R6 second packet
    ack();
    token();                                              // R10 dropped byte not sent
    check("R10 ovf sticky", ovf_err, 1);
    dma_en = 0; #1;
    check("R9 dma_req withdrawn", dma_req, 0);
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule